// File: doc/BRIEF.md
# DDR Write Burst Capture with Latency Alignment

This block forms the write data path of a low-latency DRAM device model. A write command arrives on the command clock together with a bank and a word address. The block waits a write latency that is one cycle longer than the programmed read latency. It then takes a burst of double-data-rate beats. Each cycle is modelled as two lanes: a rising-edge lane that carries the even beats and a falling-edge lane that carries the odd beats.

Every beat carries a per-byte mask and is written into an internal banked storage array. The target word is the base address plus the beat index, wrapped inside the burst-aligned block. A chain of latency stages keeps several commands in flight, so writes can be issued back to back as long as their capture windows do not collide. A write that would land on an occupied capture slot is dropped and flagged. A lookup port gives combinational access to any stored word.

Top module: `wr_burst_capture`

## Requirements
- R1: After reset every storage word reads as zero on `look_data` and `err_overlap` is low.
- R2: With read latency `cfg_rl` (3 to 8, changed only while no burst is pending), the first beat of a write accepted at clock edge t is taken from `dq_rise` at edge t+cfg_rl+1, and the stored word changes at that edge.
- R3: Each capture cycle takes two beats: beat 2h from `dq_rise` and beat 2h+1 from `dq_fall`, where h is the half of the burst.
- R4: `cfg_bl4`=0 selects a 2-beat burst taken in one cycle; `cfg_bl4`=1 selects a 4-beat burst taken over two consecutive cycles.
- R5: Beat i is written to bank `cmd_bank` at the address whose bits above the burst block come from `cmd_addr` and whose low bits (1 bit for 2 beats, 2 bits for 4 beats) equal (`cmd_addr` + i) modulo the burst length.
- R6: When bit b of the mask lane (`dm_rise` or `dm_fall`) is high for a beat, byte b of that beat (data bits 8b+7 to 8b) is not written; the other bytes are.
- R7: Writes spaced by at least the burst duration (1 cycle for 2 beats, 2 cycles for 4 beats) are all captured in full while their latency windows overlap.
- R8: `cmd_rd` issued during a pending write's latency window does not cancel it; a cycle with both `cmd_wr` and `cmd_rd` high accepts no write.
- R9: A 4-beat write issued one cycle after an accepted 4-beat write is dropped, `err_overlap` is high for the one cycle after its edge, and the earlier burst is stored in full.
- R10: `look_data` shows the current content of the word at `look_bank`/`look_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command and capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rl | input | 4 | Programmed read latency, 3 to 8 |
| cfg_bl4 | input | 1 | 1 selects 4-beat bursts, 0 selects 2-beat bursts |
| cmd_wr | input | 1 | Write command |
| cmd_rd | input | 1 | Read command |
| cmd_bank | input | 2 | Bank of the write command |
| cmd_addr | input | 4 | Base word address of the write command |
| dq_rise | input | 16 | Data beat on the rising data-clock edge |
| dq_fall | input | 16 | Data beat on the falling data-clock edge |
| dm_rise | input | 2 | Per-byte mask of the rising beat, high masks |
| dm_fall | input | 2 | Per-byte mask of the falling beat, high masks |
| look_bank | input | 2 | Bank of the word shown on look_data |
| look_addr | input | 4 | Address of the word shown on look_data |
| look_data | output | 16 | Stored word at look_bank/look_addr |
| err_overlap | output | 1 | Pulse marking a dropped, colliding write |

## Verification
The bench builds the block with its default sizes: four banks of sixteen 16-bit words, two byte lanes and a latency chain sized for read latencies up to 8. These sizes let the whole 64-word array be compared with a reference after every scenario. They also put both the shortest and the longest latency within reach, as well as both burst lengths, wrap at each burst block size, and the densest legal command spacing for each burst length.

// File: rtl/wbc_pkg.sv
`timescale 1ns/1ps
package wbc_pkg;
  // two capture lanes per clock: rising-edge beat and falling-edge beat
  localparam int LANES = 2;

  typedef enum logic {
    HALF_FIRST  = 1'b0,
    HALF_SECOND = 1'b1
  } half_e;
endpackage

// File: rtl/wbc_lat_pipe.sv
`timescale 1ns/1ps
module wbc_lat_pipe #(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 4,
  parameter int RL_W   = 4,
  parameter int RL_MAX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RL_W-1:0]   cfg_rl,
  input  logic              cfg_bl4,
  input  logic              acc_wr,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              due,
  output wbc_pkg::half_e    due_half,
  output logic [BANK_W-1:0] due_bank,
  output logic [ADDR_W-1:0] due_addr,
  output logic              err_overlap
);
  localparam int NSTG = RL_MAX + 1;

  logic [NSTG-1:0]   v_q, v_d;
  logic [BANK_W-1:0] b_q [NSTG];
  logic [BANK_W-1:0] b_d [NSTG];
  logic [ADDR_W-1:0] a_q [NSTG];
  logic [ADDR_W-1:0] a_d [NSTG];
  logic              tv_q, tv_d;
  logic [BANK_W-1:0] tb_q, tb_d;
  logic [ADDR_W-1:0] ta_q, ta_d;
  logic              err_q, err_d;
  logic              rl_ok, clash, take, busy;

  // next state: shift toward stage 0, insert at stage cfg_rl
  always_comb begin
    rl_ok = (cfg_rl <= RL_W'(RL_MAX));
    clash = acc_wr & cfg_bl4 & rl_ok & v_q[cfg_rl];
    take  = acc_wr & rl_ok & ~clash;
    v_d   = {1'b0, v_q[NSTG-1:1]};
    for (int k = 0; k < NSTG - 1; k++) begin
      b_d[k] = b_q[k+1];
      a_d[k] = a_q[k+1];
    end
    b_d[NSTG-1] = '0;
    a_d[NSTG-1] = '0;
    for (int k = 0; k < NSTG; k++) begin
      if (take && (cfg_rl == RL_W'(k))) begin
        v_d[k] = 1'b1;
        b_d[k] = in_bank;
        a_d[k] = in_addr;
      end
    end
    tv_d  = v_q[0] & cfg_bl4;
    tb_d  = b_q[0];
    ta_d  = a_q[0];
    err_d = clash;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      tv_q  <= 1'b0;
      tb_q  <= '0;
      ta_q  <= '0;
      err_q <= 1'b0;
      for (int k = 0; k < NSTG; k++) begin
        b_q[k] <= '0;
        a_q[k] <= '0;
      end
    end else begin
      v_q   <= v_d;
      tv_q  <= tv_d;
      tb_q  <= tb_d;
      ta_q  <= ta_d;
      err_q <= err_d;
      for (int k = 0; k < NSTG; k++) begin
        b_q[k] <= b_d[k];
        a_q[k] <= a_d[k];
      end
    end
  end

  assign busy        = (|v_q) | tv_q;
  assign due         = tv_q | v_q[0];
  assign due_half    = tv_q ? wbc_pkg::HALF_SECOND : wbc_pkg::HALF_FIRST;
  assign due_bank    = tv_q ? tb_q : b_q[0];
  assign due_addr    = tv_q ? ta_q : a_q[0];
  assign err_overlap = err_q;

  // R9
  one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tv_q && v_q[0]));

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(acc_wr && cfg_bl4));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($stable(cfg_rl) && $stable(cfg_bl4)));

  for (genvar k = 0; k < NSTG - 1; k++) begin : g_shift
    // R7
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_q[k+1] |=> v_q[k]);
  end
endmodule

// File: rtl/wbc_beat_map.sv
`timescale 1ns/1ps
module wbc_beat_map #(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 2,
  localparam int DW    = BYTES * 8
) (
  input  logic                             due,
  input  wbc_pkg::half_e                   half,
  input  logic                             bl4,
  input  logic [ADDR_W-1:0]                base,
  input  logic [DW-1:0]                    dq_r,
  input  logic [DW-1:0]                    dq_f,
  input  logic [BYTES-1:0]                 dm_r,
  input  logic [BYTES-1:0]                 dm_f,
  output logic [wbc_pkg::LANES*BYTES-1:0]  we,
  output logic [ADDR_W-1:0]                wa [wbc_pkg::LANES],
  output logic [DW-1:0]                    wd [wbc_pkg::LANES]
);
  logic [ADDR_W-1:0] wrap_m;
  assign wrap_m = bl4 ? ADDR_W'(3) : ADDR_W'(1);

  for (genvar l = 0; l < wbc_pkg::LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] idx;
    logic [ADDR_W-1:0] sum;
    logic [BYTES-1:0]  msk;
    assign idx = {{(ADDR_W-2){1'b0}}, half == wbc_pkg::HALF_SECOND, 1'(l)};
    assign sum = base + idx;
    assign wa[l] = (base & ~wrap_m) | (sum & wrap_m);
    if (l == 0) begin : g_rise
      assign wd[l] = dq_r;
      assign msk   = dm_r;
    end else begin : g_fall
      assign wd[l] = dq_f;
      assign msk   = dm_f;
    end
    assign we[l*BYTES +: BYTES] = {BYTES{due}} & ~msk;
  end
endmodule

// File: rtl/wbc_store.sv
`timescale 1ns/1ps
module wbc_store #(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 4,
  parameter int BYTES  = 2,
  localparam int DW    = BYTES * 8,
  localparam int WORDS = 1 << (BANK_W + ADDR_W)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [wbc_pkg::LANES*BYTES-1:0] we,
  input  logic [BANK_W-1:0]               bank,
  input  logic [ADDR_W-1:0]               wa [wbc_pkg::LANES],
  input  logic [DW-1:0]                   wd [wbc_pkg::LANES],
  input  logic [BANK_W-1:0]               look_bank,
  input  logic [ADDR_W-1:0]               look_addr,
  output logic [DW-1:0]                   look_data
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < WORDS; k++) mem[k] <= '0;
    end else begin
      for (int l = 0; l < wbc_pkg::LANES; l++) begin
        for (int b = 0; b < BYTES; b++) begin
          if (we[l*BYTES+b]) mem[{bank, wa[l]}][b*8 +: 8] <= wd[l][b*8 +: 8];
        end
      end
    end
  end

  assign look_data = mem[{look_bank, look_addr}];
endmodule

// File: rtl/wr_burst_capture.sv
`timescale 1ns/1ps
module wr_burst_capture #(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 4,
  parameter int BYTES  = 2,
  parameter int RL_W   = 4,
  parameter int RL_MAX = 8,
  localparam int DW    = BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RL_W-1:0]   cfg_rl,
  input  logic              cfg_bl4,
  input  logic              cmd_wr,
  input  logic              cmd_rd,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DW-1:0]     dq_rise,
  input  logic [DW-1:0]     dq_fall,
  input  logic [BYTES-1:0]  dm_rise,
  input  logic [BYTES-1:0]  dm_fall,
  input  logic [BANK_W-1:0] look_bank,
  input  logic [ADDR_W-1:0] look_addr,
  output logic [DW-1:0]     look_data,
  output logic              err_overlap
);
  localparam int LANES = wbc_pkg::LANES;

  logic                    acc_wr;
  logic                    due;
  wbc_pkg::half_e          due_half;
  logic [BANK_W-1:0]       due_bank;
  logic [ADDR_W-1:0]       due_addr;
  logic [LANES*BYTES-1:0]  we;
  logic [ADDR_W-1:0]       wa [LANES];
  logic [DW-1:0]           wd [LANES];

  // one command per cycle on the bus: a read in the same cycle blocks the write
  assign acc_wr = cmd_wr & ~cmd_rd;

  wbc_lat_pipe #(
    .BANK_W(BANK_W), .ADDR_W(ADDR_W), .RL_W(RL_W), .RL_MAX(RL_MAX)
  ) u_pipe (
    .clk(clk), .rst_n(rst_n), .cfg_rl(cfg_rl), .cfg_bl4(cfg_bl4),
    .acc_wr(acc_wr), .in_bank(cmd_bank), .in_addr(cmd_addr),
    .due(due), .due_half(due_half), .due_bank(due_bank), .due_addr(due_addr),
    .err_overlap(err_overlap)
  );

  wbc_beat_map #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_map (
    .due(due), .half(due_half), .bl4(cfg_bl4), .base(due_addr),
    .dq_r(dq_rise), .dq_f(dq_fall), .dm_r(dm_rise), .dm_f(dm_fall),
    .we(we), .wa(wa), .wd(wd)
  );

  wbc_store #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .BYTES(BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .bank(due_bank), .wa(wa), .wd(wd),
    .look_bank(look_bank), .look_addr(look_addr), .look_data(look_data)
  );

  // R5
  lane_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|we[BYTES-1:0]) && (|we[2*BYTES-1:BYTES])) |-> (wa[0] != wa[1]));
endmodule

// File: tb/wr_burst_capture_tb.sv
`timescale 1ns/1ps
module wr_burst_capture_tb;
  localparam int NCYC = 4096;
  // row: rl[11:8], bl4[7], gap[6:4], mask mode[3:2]
  localparam logic [11:0] VEC [8] = '{12'h314, 12'h4A4, 12'h520, 12'h6B4,
                                      12'h714, 12'h8A4, 12'h3A0, 12'h834};

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0]  cfg_rl;
  logic        cfg_bl4;
  logic        cmd_wr, cmd_rd;
  logic [1:0]  cmd_bank;
  logic [3:0]  cmd_addr;
  logic [15:0] dq_rise, dq_fall;
  logic [1:0]  dm_rise, dm_fall;
  logic [1:0]  look_bank;
  logic [3:0]  look_addr;
  logic [15:0] look_data;
  logic        err_overlap;

  logic        p_wr [NCYC];
  logic        p_rd [NCYC];
  logic [1:0]  p_bk [NCYC];
  logic [3:0]  p_ad [NCYC];
  logic [15:0] p_dr [NCYC];
  logic [15:0] p_df [NCYC];
  logic [1:0]  p_mr [NCYC];
  logic [1:0]  p_mf [NCYC];
  logic [15:0] refm [64];

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wr_burst_capture u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_rl(cfg_rl), .cfg_bl4(cfg_bl4),
    .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dm_rise(dm_rise), .dm_fall(dm_fall),
    .look_bank(look_bank), .look_addr(look_addr), .look_data(look_data),
    .err_overlap(err_overlap)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // drive the inputs for the next edge from the schedule
  always @(negedge clk) begin
    cmd_wr   = p_wr[cyc+1];
    cmd_rd   = p_rd[cyc+1];
    cmd_bank = p_bk[cyc+1];
    cmd_addr = p_ad[cyc+1];
    dq_rise  = p_dr[cyc+1];
    dq_fall  = p_df[cyc+1];
    dm_rise  = p_mr[cyc+1];
    dm_fall  = p_mf[cyc+1];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  function automatic int wslot(input int bk, input int ad);
    return bk * 16 + ad;
  endfunction

  // mm: 0 no mask, 1 random mask, 2 all masked; keep: update reference
  task automatic sched(input int t, input int bk, input int ad, input bit bl4,
                       input int rl, input int mm, input bit keep);
    int n;
    n = bl4 ? 4 : 2;
    p_wr[t] = 1'b1;
    p_bk[t] = 2'(bk);
    p_ad[t] = 4'(ad);
    for (int i = 0; i < n; i++) begin
      logic [15:0] d;
      logic [1:0]  m;
      int c, a;
      d = 16'($urandom);
      m = (mm == 2) ? 2'b11 : (mm == 1) ? 2'($urandom) : 2'b00;
      c = t + rl + 1 + i / 2;
      if (i % 2 == 0) begin p_dr[c] = d; p_mr[c] = m; end
      else            begin p_df[c] = d; p_mf[c] = m; end
      a = (ad & ~(n - 1)) | ((ad + i) & (n - 1));
      if (keep) begin
        for (int b = 0; b < 2; b++)
          if (!m[b]) refm[wslot(bk, a)][b*8 +: 8] = d[b*8 +: 8];
      end
    end
  endtask

  task automatic cmp_all(input string tag);
    int errs, fa, fe;
    errs = 0; fa = 0; fe = 0;
    for (int k = 0; k < 64; k++) begin
      look_bank = 2'(k / 16);
      look_addr = 4'(k % 16);
      #0.01;
      if (look_data !== refm[k]) begin
        if (errs == 0) begin fa = int'(look_data); fe = int'(refm[k]); end
        errs++;
      end
    end
    chk(errs == 0, tag, fa, fe);
  endtask

  task automatic set_cfg(input int rl, input bit bl4);
    @(negedge clk);
    cfg_rl  = 4'(rl);
    cfg_bl4 = bl4;
    wait_to(cyc + 2);
  endtask

  initial begin
    #750000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int t, old, rl, gap, mm;
    bit bl4;
    for (int k = 0; k < NCYC; k++) begin
      p_wr[k] = 1'b0; p_rd[k] = 1'b0; p_bk[k] = 2'd0; p_ad[k] = 4'd0;
      p_dr[k] = 16'hA5C3; p_df[k] = 16'h3C5A; p_mr[k] = 2'b00; p_mf[k] = 2'b00;
    end
    for (int k = 0; k < 64; k++) refm[k] = 16'h0000;
    rst_n = 1'b0; cfg_rl = 4'd4; cfg_bl4 = 1'b0;
    look_bank = 2'd0; look_addr = 4'd0;
    wait_to(4);
    rst_n = 1'b1;
    wait_to(6);

    // R1 and R10: reset contents through the lookup port
    cmp_all("R1 R10 reset storage");
    chk(err_overlap == 1'b0, "R1 err_overlap after reset", int'(err_overlap), 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int r = 0; r < 8; r++) begin
      rl  = int'(VEC[r][11:8]);
      bl4 = VEC[r][7];
      gap = int'(VEC[r][6:4]);
      mm  = int'(VEC[r][3:2]);
      set_cfg(rl, bl4);
      t = cyc + 2;
      for (int j = 0; j < 8; j++)
        sched(t + j * gap, int'($urandom % 4), int'($urandom % 16), bl4, rl, mm, 1'b1);
      wait_to(t + 7 * gap + rl + 5);
      cmp_all($sformatf("R2 R3 R4 R7 table row %0d", r));
    end

    // R2: exact edge at which the first beat lands
    set_cfg(6, 1'b0);
    t = cyc + 3;
    old = int'(refm[wslot(0, 10)]);
    sched(t, 0, 10, 1'b0, 6, 0, 1'b1);
    wait_to(t + 6);
    look_bank = 2'd0; look_addr = 4'd10; #0.01;
    chk(look_data === 16'(old), "R2 word unchanged one edge before capture", int'(look_data), old);
    wait_to(t + 7);
    look_bank = 2'd0; look_addr = 4'd10; #0.01;
    chk(look_data === refm[wslot(0, 10)], "R2 R3 word written at edge t+rl+1",
        int'(look_data), int'(refm[wslot(0, 10)]));

    // R5: wrap of a 4-beat burst from address 7 onto 7,4,5,6
    set_cfg(4, 1'b1);
    t = cyc + 2;
    sched(t, 2, 7, 1'b1, 4, 0, 1'b1);
    wait_to(t + 8);
    cmp_all("R4 R5 wrap inside 4-word block");
    // R5: 2-beat wrap from address 13 onto 13,12
    set_cfg(3, 1'b0);
    t = cyc + 2;
    sched(t, 3, 13, 1'b0, 3, 0, 1'b1);
    wait_to(t + 6);
    cmp_all("R5 wrap inside 2-word block");

    // R6: fully masked burst leaves storage as it was
    set_cfg(5, 1'b1);
    t = cyc + 2;
    sched(t, 1, 0, 1'b1, 5, 2, 1'b1);
    wait_to(t + 9);
    cmp_all("R6 fully masked burst writes nothing");

    // R8: reads inside the latency window do not cancel the write
    t = cyc + 2;
    sched(t, 1, 4, 1'b1, 5, 0, 1'b1);
    p_rd[t+2] = 1'b1;
    p_rd[t+5] = 1'b1;
    wait_to(t + 9);
    cmp_all("R8 read during latency keeps burst");
    // R8: write together with read is not accepted
    t = cyc + 2;
    sched(t, 3, 8, 1'b1, 5, 0, 1'b0);
    p_rd[t] = 1'b1;
    wait_to(t + 9);
    cmp_all("R8 write with read in same cycle ignored");

    // R9: colliding 4-beat write one cycle later
    set_cfg(4, 1'b1);
    t = cyc + 2;
    sched(t, 1, 8, 1'b1, 4, 0, 1'b1);
    p_wr[t+1] = 1'b1; p_bk[t+1] = 2'd2; p_ad[t+1] = 4'd8;
    wait_to(t);
    chk(err_overlap == 1'b0, "R9 no error after accepted write", int'(err_overlap), 0);
    wait_to(t + 1);
    chk(err_overlap == 1'b1, "R9 error pulse after colliding write", int'(err_overlap), 1);
    wait_to(t + 2);
    chk(err_overlap == 1'b0, "R9 error pulse lasts one cycle", int'(err_overlap), 0);
    wait_to(t + 10);
    cmp_all("R9 first burst kept, colliding write dropped");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule